// File: doc/BRIEF.md
# Unaligned Load Split-and-Merge Unit

This unit sits between a load requester and a memory port that can only return whole, word-aligned data words. A requester hands it a byte address and an access size of one, two or four bytes. The unit works out whether the requested bytes all lie inside one aligned word or run across the boundary into the next one. It then issues one or two aligned word reads. It shifts the words into place and merges them into a right-justified, zero-extended result.

The memory port has a valid/ready request channel and returns read data one or more cycles later with a data-valid pulse. Only one read is outstanding at any time. When trap mode is selected, an access that is not naturally aligned does not touch memory. It completes at once with a fault flag instead. A small debug output reports how many word reads the last access used.

Top module: `unaligned_load_unit`

## Requirements
- R1: Every read address driven on `mem_req_addr` has its two least significant bits at zero.
- R2: An access whose bytes fit in one aligned word makes exactly one read, of the word that contains the start address, and reports `dbg_reads` = 1.
- R3: An access that crosses a word boundary makes exactly two reads. The first is the word containing the start address and the second is the word 4 bytes above it. The access reports `dbg_reads` = 2.
- R4: A boundary is crossed when the byte offset plus the byte count exceeds 4. A 4-byte access therefore crosses at offsets 1, 2 and 3, a 2-byte access only at offset 3, and a 1-byte access never.
- R5: `req_size` code 0 selects 1 byte, code 1 selects 2 bytes, and codes 2 and 3 select 4 bytes. The byte at the start address appears in `rsp_data[7:0]` and the following bytes appear in ascending order above it (little-endian). All unused upper bytes are zero.
- R6: With `trap_en` high, a request whose address is not a multiple of its byte count completes with `rsp_fault` = 1, `rsp_data` = 0 and `dbg_reads` = 0, and issues no memory read. A naturally aligned request in trap mode completes normally.
- R7: `rsp_valid` is a single-cycle pulse, one per accepted request. `req_ready` is high only while the unit is idle, and a `req_valid` presented while `req_ready` is low is ignored.
- R8: Once raised, `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. A new read is issued only after the previous read's data has returned.
- R9: After reset, `req_ready` is 1 and `mem_req_valid`, `rsp_valid` and `dbg_reads` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, so a request is taken this cycle |
| req_addr | input | AW | Byte address of the load |
| req_size | input | 2 | Size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| trap_en | input | 1 | Fault on misaligned requests instead of splitting |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | AW | Word-aligned read address |
| mem_rdata_valid | input | 1 | Read data valid pulse |
| mem_rdata | input | DW | Read data word |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | DW | Right-justified, zero-extended load data |
| rsp_fault | output | 1 | Misalignment fault flag |
| dbg_reads | output | 2 | Word reads used by the last access |

## Verification
The embedded assertions check on every cycle the properties that hold regardless of the data: aligned read addresses, the request held stable until it is taken, single-cycle responses, the second read landing one word above the first, and the match between the number of reads actually handshaken and the reported read count, with none for a fault. The byte assembly itself, the crossing decision for each size and offset, the zero-extension, the trap decision, and the ignoring of requests while busy can only be shown by the bench's scenarios. The bench compares every response against values computed from a byte-pattern memory model under varying ready and latency.

// File: rtl/ulsm_pkg.sv
package ulsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ0,
    ST_WAIT0,
    ST_REQ1,
    ST_WAIT1
  } ulsm_state_e;

  localparam int SIZE_CODE_W = 2;
endpackage

// File: rtl/ulsm_span.sv
module ulsm_span #(
  parameter int DW = 32
) (
  input  logic [$clog2(DW/8)-1:0]   off,
  input  logic [1:0]                size,
  output logic [$clog2(DW/8):0]     nbytes,
  output logic                      crosses,
  output logic                      misaligned
);
  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);

  logic [OFFW:0] mask;
  logic [OFFW:0] end_pos;

  always_comb begin
    if (int'(size) >= OFFW) nbytes = (OFFW+1)'(BYTES);
    else                    nbytes = (OFFW+1)'(1) << size;
    mask       = nbytes - (OFFW+1)'(1);
    end_pos    = {1'b0, off} + nbytes;
    crosses    = end_pos > (OFFW+1)'(BYTES);
    misaligned = ({1'b0, off} & mask) != '0;
  end
endmodule

// File: rtl/ulsm_merge.sv
module ulsm_merge #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]             lo_word,
  input  logic [DW-1:0]             hi_word,
  input  logic [$clog2(DW/8)-1:0]   off,
  input  logic [$clog2(DW/8):0]     nbytes,
  output logic [DW-1:0]             data
);
  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);

  logic [DW-1:0] shifted;

  // low word moves down by the offset, high word fills in from above
  always_comb begin
    shifted = DW'({hi_word, lo_word} >> {off, 3'b000});
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign data[b*8 +: 8] = ((OFFW+1)'(b) < nbytes) ? shifted[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/ulsm_ctrl.sv
module ulsm_ctrl
  import ulsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_addr,
  input  logic                      trap_en,
  input  logic [$clog2(DW/8):0]     span_nbytes,
  input  logic                      span_cross,
  input  logic                      span_misal,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [AW-1:0]             mem_req_addr,
  input  logic                      mem_rdata_valid,
  input  logic [DW-1:0]             mem_rdata,
  input  logic [DW-1:0]             merge_data,
  output logic [$clog2(DW/8)-1:0]   off_q,
  output logic [$clog2(DW/8):0]     nbytes_q,
  output logic [DW-1:0]             word0_q,
  output logic                      second_phase,
  output logic                      rsp_valid,
  output logic [DW-1:0]             rsp_data,
  output logic                      rsp_fault,
  output logic [1:0]                dbg_reads
);
  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);

  ulsm_state_e state;
  logic        cross_q;

  assign req_ready    = (state == ST_IDLE) && !rsp_valid;
  assign second_phase = (state == ST_WAIT1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_fault     <= 1'b0;
      dbg_reads     <= 2'd0;
      off_q         <= '0;
      nbytes_q      <= '0;
      cross_q       <= 1'b0;
      word0_q       <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            off_q    <= req_addr[OFFW-1:0];
            nbytes_q <= span_nbytes;
            cross_q  <= span_cross;
            if (trap_en && span_misal) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_data  <= '0;
              dbg_reads <= 2'd0;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
              state         <= ST_REQ0;
            end
          end
        end
        ST_REQ0: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_WAIT0;
          end
        end
        ST_WAIT0: begin
          if (mem_rdata_valid) begin
            word0_q <= mem_rdata;
            if (cross_q) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= mem_req_addr + AW'(BYTES);
              state         <= ST_REQ1;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_data  <= merge_data;
              dbg_reads <= 2'd1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_REQ1: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_WAIT1;
          end
        end
        ST_WAIT1: begin
          if (mem_rdata_valid) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_data  <= merge_data;
            dbg_reads <= 2'd2;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[OFFW-1:0] == '0)); // R1
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R7
  AST_NO_REQ_WHILE_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_rdata_valid |-> !mem_req_valid); // R8
endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          trap_en,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rdata_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fault,
  output logic [1:0]    dbg_reads
);
  localparam int BYTES = DW / 8;
  localparam int OFFW  = $clog2(BYTES);

  logic [OFFW:0]   span_nbytes;
  logic            span_cross;
  logic            span_misal;
  logic [OFFW-1:0] off_q;
  logic [OFFW:0]   nbytes_q;
  logic [DW-1:0]   word0_q;
  logic            second_phase;
  logic [DW-1:0]   lo_word;
  logic [DW-1:0]   hi_word;
  logic [DW-1:0]   merge_data;

  ulsm_span #(.DW(DW)) span_i (
    .off        (req_addr[OFFW-1:0]),
    .size       (req_size),
    .nbytes     (span_nbytes),
    .crosses    (span_cross),
    .misaligned (span_misal)
  );

  assign lo_word = second_phase ? word0_q   : mem_rdata;
  assign hi_word = second_phase ? mem_rdata : '0;

  ulsm_merge #(.DW(DW)) merge_i (
    .lo_word (lo_word),
    .hi_word (hi_word),
    .off     (off_q),
    .nbytes  (nbytes_q),
    .data    (merge_data)
  );

  ulsm_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_addr        (req_addr),
    .trap_en         (trap_en),
    .span_nbytes     (span_nbytes),
    .span_cross      (span_cross),
    .span_misal      (span_misal),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_rdata_valid (mem_rdata_valid),
    .mem_rdata       (mem_rdata),
    .merge_data      (merge_data),
    .off_q           (off_q),
    .nbytes_q        (nbytes_q),
    .word0_q         (word0_q),
    .second_phase    (second_phase),
    .rsp_valid       (rsp_valid),
    .rsp_data        (rsp_data),
    .rsp_fault       (rsp_fault),
    .dbg_reads       (dbg_reads)
  );

  // read bookkeeping used only by the properties below
  logic [1:0]    rd_cnt;
  logic [AW-1:0] last_rd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt       <= 2'd0;
      last_rd_addr <= '0;
    end else if (req_valid && req_ready) begin
      rd_cnt <= 2'd0;
    end else if (mem_req_valid && mem_req_ready) begin
      rd_cnt       <= rd_cnt + 2'd1;
      last_rd_addr <= mem_req_addr;
    end
  end

  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rd_cnt == 2'd0)); // R6
  AST_READ_COUNT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rd_cnt == dbg_reads)); // R2
  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && rd_cnt == 2'd1) |->
      (mem_req_addr == last_rd_addr + AW'(BYTES))); // R3
endmodule

// File: tb/unaligned_load_unit_tb_top.sv
module unaligned_load_unit_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic [31:0] data;
    logic        fault;
    logic [1:0]  reads;
    logic [31:0] waddr;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd0;
  logic          trap_en = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rdata_valid;
  logic [DW-1:0] mem_rdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_fault;
  logic [1:0]    dbg_reads;

  int checks = 0;
  int errors = 0;
  int n_sent = 0;
  int n_rsp  = 0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  unaligned_load_unit #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .trap_en(trap_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rdata_valid(mem_rdata_valid),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault), .dbg_reads(dbg_reads)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'((a * 32'd29) ^ 32'h5A) ^ a[15:8];
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] wa);
    return {mbyte(wa + 32'd3), mbyte(wa + 32'd2), mbyte(wa + 32'd1), mbyte(wa)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // memory model: ready toggles by pattern, latency 1 or 2 cycles
  logic [3:0]  cyc;
  logic        pend;
  logic        pcnt;
  logic [31:0] paddr;
  int          hs_cnt;
  logic [31:0] hs_addr0, hs_addr1;
  int          hs_snap = 0;

  always @(posedge clk) begin
    if (rst) begin
      cyc <= '0; pend <= 1'b0; pcnt <= 1'b0; paddr <= '0;
      mem_req_ready <= 1'b0; mem_rdata_valid <= 1'b0; mem_rdata <= '0;
      hs_cnt <= 0; hs_addr0 <= '0; hs_addr1 <= '0;
    end else begin
      cyc <= cyc + 4'd1;
      mem_req_ready <= (cyc[1:0] != 2'b01);
      mem_rdata_valid <= 1'b0;
      if (pend) begin
        if (pcnt == 1'b0) begin
          mem_rdata_valid <= 1'b1;
          mem_rdata <= mword(paddr);
          pend <= 1'b0;
        end else pcnt <= 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1;
        pcnt <= cyc[0];
        paddr <= mem_req_addr;
        if (hs_cnt == hs_snap) hs_addr0 <= mem_req_addr;
        else hs_addr1 <= mem_req_addr;
        hs_cnt <= hs_cnt + 1;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t e;
      string tg;
      n_rsp++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected response", rsp_data, 32'h0);
      end else begin
        e = exp_q.pop_front();
        tg = (e.reads == 2'd0) ? "R6" : (e.reads == 2'd1) ? "R2" : "R3";
        check(rsp_data == e.data, "R5 data", rsp_data, e.data);
        check(rsp_fault == e.fault, "R6 fault", 32'(rsp_fault), 32'(e.fault));
        check(dbg_reads == e.reads, {tg, " dbg_reads"}, 32'(dbg_reads), 32'(e.reads));
        check((hs_cnt - hs_snap) == int'(e.reads), {tg, " read count"},
              32'(hs_cnt - hs_snap), 32'(e.reads));
        if (e.reads != 2'd0)
          check(hs_addr0 == e.waddr, "R1 first word address", hs_addr0, e.waddr);
        if (e.reads == 2'd2)
          check(hs_addr1 == e.waddr + 32'd4, "R3 second word address", hs_addr1,
                e.waddr + 32'd4);
      end
      hs_snap = hs_cnt;
    end
  end

  task automatic run_load(input logic [31:0] a, input logic [1:0] sz, input logic tr,
                          input bit poke_busy);
    exp_t e;
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    e.data  = '0;
    e.waddr = {a[31:2], 2'b00};
    if (tr && ((a & 32'(n - 1)) != 0)) begin
      e.fault = 1'b1;
      e.reads = 2'd0;
    end else begin
      e.fault = 1'b0;
      e.reads = (int'(a[1:0]) + n > 4) ? 2'd2 : 2'd1; // R4
      for (int i = 0; i < n; i++) e.data[i*8 +: 8] = mbyte(a + 32'(i));
    end
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; trap_en = tr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_sent++;
    if (poke_busy) begin
      while (!req_ready) begin
        req_valid = 1'b1; req_addr = 32'h0000_0103; req_size = 2'd2; trap_en = 1'b0;
        @(negedge clk);
      end
      req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 req_ready", 32'(req_ready), 32'd1);
    check(mem_req_valid == 1'b0, "R9 mem_req_valid", 32'(mem_req_valid), 32'd0);
    check(rsp_valid == 1'b0, "R9 rsp_valid", 32'(rsp_valid), 32'd0);
    check(dbg_reads == 2'd0, "R9 dbg_reads", 32'(dbg_reads), 32'd0);

    // R4 R5: every size at every offset, split mode
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        run_load(32'h0000_0040 + 32'(o), 2'(s), 1'b0, 1'b0);
    // different base addresses
    for (int k = 0; k < 6; k++)
      run_load(32'h0000_1230 + 32'(k * 7), 2'(k % 3), 1'b0, 1'b0);
    // R6: trap mode, misaligned and aligned
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++)
        run_load(32'h0000_0200 + 32'(o), 2'(s), 1'b1, 1'b0);
    // back-to-back faults
    run_load(32'h0000_0301, 2'd2, 1'b1, 1'b0);
    run_load(32'h0000_0302, 2'd2, 1'b1, 1'b0);
    // R7: requests presented while busy are ignored
    run_load(32'h0000_0503, 2'd2, 1'b0, 1'b1);
    run_load(32'h0000_0601, 2'd1, 1'b0, 1'b1);
    // address wrap at the top of the space
    run_load(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b0);

    for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R7 all responses seen", 32'(exp_q.size()), 32'd0);
    check(n_rsp == n_sent, "R7 one response per request", 32'(n_rsp), 32'(n_sent));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule